// File: doc/BRIEF.md
# Clocked Synchronous Full-Duplex Serial Transceiver

This block is a serial master for clocked synchronous links. It generates its own serial clock and, in one 8-bit frame, shifts a byte out on the data output while it shifts a byte in from the data input. A small CPU-side register file holds the byte to send, the byte that has arrived, a status byte and the controls: transmit and receive enables and an 8-bit clock divider.

The status flags clear themselves as a side effect of CPU access. Writing the transmit byte clears transmit-empty, and reading the received byte clears receive-full. A frame that completes while the previous received byte is still unread raises overrun. Overrun then stops all further frames in both directions until software writes it back to zero. The serial clock toggles only while a frame is in progress and rests high between frames.

Register map (3-bit address): 0 = transmit byte (write), 1 = received byte (read), 2 = status (read; write for overrun clear), 3 = control (bit 0 transmit enable, bit 1 receive enable), 4 = divider. Status bits: bit 0 transmit-empty, bit 1 transmit-end, bit 2 receive-full, bit 3 overrun. Addresses 0, 5, 6 and 7 read as zero.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A synchronous active-high reset sets status to transmit-empty=1, transmit-end=1, receive-full=0 and overrun=0 (status reads 0x03). It also clears control and divider to 0 and drives the serial clock and data output high.
- R2: A write to address 0 stores the byte and clears transmit-empty (bit 0) and transmit-end (bit 1) on the next cycle. When a frame starts, the byte moves into the shifter and transmit-empty returns to 1, so the next byte can be written during the frame.
- R3: A frame is 8 bits sent LSB first. The data output changes only when the serial clock falls. Each clock half lasts divider+1 system cycles, and the serial clock stays high whenever no frame is in progress.
- R4: Input is sampled on each rising serial clock edge, and the eighth sample becomes bit 7. At frame end, with receive enabled and receive-full at 0, the byte appears at address 1 and receive-full (bit 2) is set.
- R5: A read of address 1 clears receive-full on the next cycle.
- R6: When a frame ends with receive enabled and receive-full already 1, overrun (bit 3) is set, the stored received byte is kept and the new byte is discarded.
- R7: While overrun is 1 no frame starts. Writing status with bit 3 = 0 clears overrun, and writing it with bit 3 = 1 leaves it set.
- R8: At the end of a frame with no byte pending, the serial clock stops high and transmit-end is set along with transmit-empty.
- R9: With transmit enabled, a frame starts when a byte is pending. With only receive enabled, frames start whenever idle and shift out ones. With both disabled, no frame starts. With receive disabled, frames leave receive-full and the stored byte unchanged.
- R10: A byte written during a frame is sent in a following frame that starts one system cycle after the current one ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | CPU write strobe |
| rdEn | input | 1 | CPU read strobe (side effects at address 1) |
| addr | input | 3 | Register address |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | CPU read data, combinational from addr |
| sclkOut | output | 1 | Serial clock, idle high |
| txdOut | output | 1 | Serial data out |
| rxdIn | input | 1 | Serial data in |

## Verification
The assertions check on every cycle the flag invariants. Transmit-end never stands without transmit-empty, and a data-register write or read clears its flag on the next cycle. Overrun blocks every frame start, a write of 1 leaves it set, and an overrun keeps the stored byte. The serial clock rests high when idle and holds steady between divider ticks. Only the bench's scenarios can show the bit order on the wire, the received byte values under loopback and inversion, the per-divider timing, the back-to-back frame spacing and the behaviour of each enable combination. They do so by comparing pins and register reads against a behavioural model on every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_TXBUF = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RXBUF = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DIV   = 3'd4;

  localparam int ST_TXEMPTY = 0;
  localparam int ST_TXEND   = 1;
  localparam int ST_RXFULL  = 2;
  localparam int ST_OVR     = 3;

  typedef struct packed {
    logic startFrame;
    logic riseEdge;
    logic fallEdge;
    logic frameEnd;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int NBITS = DATA_W,
  parameter int DIVW  = DIV_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] divVal,
  input  logic            txEn,
  input  logic            rxEn,
  input  logic            txEmpty,
  input  logic            overrun,
  output xcvrStrobe_t     stb,
  output logic            sclk
);
  localparam int BCW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(NBITS - 1);

  logic            busy;
  logic [DIVW-1:0] halfCnt;
  logic [BCW-1:0]  bitCnt;
  logic            startNow;
  logic            tick;

  always_comb begin
    startNow = !busy && !overrun && ((txEn && !txEmpty) || (!txEn && rxEn));
    tick     = busy && (halfCnt == '0);
    stb.startFrame = startNow;
    stb.riseEdge   = tick && !sclk;
    stb.fallEdge   = tick && sclk && (bitCnt != LAST_BIT);
    stb.frameEnd   = tick && sclk && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b1;
      halfCnt <= '0;
      bitCnt  <= '0;
    end else if (startNow) begin
      busy    <= 1'b1;
      sclk    <= 1'b0;
      halfCnt <= divVal;
      bitCnt  <= '0;
    end else if (busy) begin
      if (halfCnt != '0) begin
        halfCnt <= halfCnt - 1'b1;
      end else begin
        halfCnt <= divVal;
        if (!sclk) begin
          sclk <= 1'b1;
        end else if (bitCnt == LAST_BIT) begin
          busy <= 1'b0;
        end else begin
          sclk   <= 1'b0;
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R3
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk);

  // R3
  half_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && halfCnt != '0 && !startNow) |=> $stable(sclk));
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int NBITS = DATA_W,
  parameter int DIVW  = DIV_W,
  parameter int AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvrStrobe_t      stb,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AW-1:0]    addr,
  input  logic [NBITS-1:0] wrData,
  input  logic             rxd,
  output logic [NBITS-1:0] rdData,
  output logic             txd,
  output logic             txEn,
  output logic             rxEn,
  output logic             txEmpty,
  output logic             overrun,
  output logic [DIVW-1:0]  divVal
);
  logic [NBITS-1:0] txBuf, txShift, rxShift, rxBuf;
  logic             txEnd, rxFull;
  logic             wrTx, rdRx, wrStat, wrCtl, wrDiv;
  logic [NBITS-1:0] loadVal;

  always_comb begin
    wrTx    = wrEn && (addr == ADDR_TXBUF);
    rdRx    = rdEn && (addr == ADDR_RXBUF);
    wrStat  = wrEn && (addr == ADDR_STAT);
    wrCtl   = wrEn && (addr == ADDR_CTL);
    wrDiv   = wrEn && (addr == ADDR_DIV);
    loadVal = txEn ? txBuf : '1;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_RXBUF: rdData = rxBuf;
      ADDR_STAT: begin
        rdData[ST_TXEMPTY] = txEmpty;
        rdData[ST_TXEND]   = txEnd;
        rdData[ST_RXFULL]  = rxFull;
        rdData[ST_OVR]     = overrun;
      end
      ADDR_CTL: begin
        rdData[0] = txEn;
        rdData[1] = rxEn;
      end
      ADDR_DIV: rdData[DIVW-1:0] = divVal;
      default: rdData = '0;
    endcase
  end

  // shifters and output pin
  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '1;
      rxShift <= '0;
      txd     <= 1'b1;
    end else begin
      if (stb.startFrame) begin
        txShift <= loadVal;
        txd     <= loadVal[0];
      end else if (stb.fallEdge) begin
        txShift <= {1'b1, txShift[NBITS-1:1]};
        txd     <= txShift[1];
      end
      if (stb.riseEdge) rxShift <= {rxd, rxShift[NBITS-1:1]};
    end
  end

  // CPU-visible registers and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      txBuf   <= '0;
      rxBuf   <= '0;
      txEmpty <= 1'b1;
      txEnd   <= 1'b1;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
      divVal  <= '0;
    end else begin
      if (stb.startFrame && txEn) txEmpty <= 1'b1;
      if (stb.frameEnd && txEmpty) txEnd <= 1'b1;
      if (wrTx) begin
        txBuf   <= wrData;
        txEmpty <= 1'b0;
        txEnd   <= 1'b0;
      end
      if (stb.frameEnd && rxEn && !rxFull) begin
        rxBuf  <= rxShift;
        rxFull <= 1'b1;
      end else if (rdRx) begin
        rxFull <= 1'b0;
      end
      if (stb.frameEnd && rxEn && rxFull) overrun <= 1'b1;
      else if (wrStat && !wrData[ST_OVR]) overrun <= 1'b0;
      if (wrCtl) begin
        txEn <= wrData[0];
        rxEn <= wrData[1];
      end
      if (wrDiv) divVal <= wrData[DIVW-1:0];
    end
  end

  // R2
  tx_write_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    wrTx |=> (!txEmpty && !txEnd));

  // R8
  end_implies_empty_chk: assert property (@(posedge clk) disable iff (rst)
    txEnd |-> txEmpty);

  // R5
  rx_read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (rdRx && !stb.frameEnd) |=> !rxFull);

  // R6
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    (stb.frameEnd && rxEn && rxFull) |=> (overrun && $stable(rxBuf)));

  // R7
  overrun_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !stb.startFrame);

  // R7
  overrun_write_one_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && wrStat && wrData[ST_OVR]) |=> overrun);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sclkOut,
  output logic              txdOut,
  input  logic              rxdIn
);
  xcvrStrobe_t      stb;
  logic             txEn, rxEn, txEmpty, overrun;
  logic [DIV_W-1:0] divVal;

  xcvr_ctrl #(.NBITS(DATA_W), .DIVW(DIV_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .divVal  (divVal),
    .txEn    (txEn),
    .rxEn    (rxEn),
    .txEmpty (txEmpty),
    .overrun (overrun),
    .stb     (stb),
    .sclk    (sclkOut)
  );

  xcvr_datapath #(.NBITS(DATA_W), .DIVW(DIV_W), .AW(ADDR_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .rxd     (rxdIn),
    .rdData  (rdData),
    .txd     (txdOut),
    .txEn    (txEn),
    .rxEn    (rxEn),
    .txEmpty (txEmpty),
    .overrun (overrun),
    .divVal  (divVal)
  );
endmodule

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0] addr = 3'd2;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sclkOut, txdOut, rxdIn;
  logic       rxInv = 1'b0;

  int compared = 0, mismatched = 0, cyc = 0;
  bit started = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxdIn = txdOut ^ rxInv;

  sync_serial_xcvr u_sync_serial_xcvr (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .sclkOut(sclkOut),
    .txdOut(txdOut), .rxdIn(rxdIn)
  );

  // behavioural reference model
  int mBusy, mSclk, mTxd, mCnt, mBit;
  int mTxBuf, mTxSh, mRxSh, mRxBuf;
  int mTxEmpty, mTxEnd, mRxFull, mOvr, mTxEn, mRxEn, mDiv;

  always @(posedge clk) begin
    int start, endNow, pTxEmpty, pRxFull, pBusy, pSclk, pCnt, pBit;
    if (rst) begin
      mBusy = 0; mSclk = 1; mTxd = 1; mCnt = 0; mBit = 0;
      mTxBuf = 0; mTxSh = 255; mRxSh = 0; mRxBuf = 0;
      mTxEmpty = 1; mTxEnd = 1; mRxFull = 0; mOvr = 0;
      mTxEn = 0; mRxEn = 0; mDiv = 0;
      started = 1;
    end else begin
      pTxEmpty = mTxEmpty; pRxFull = mRxFull;
      pBusy = mBusy; pSclk = mSclk; pCnt = mCnt; pBit = mBit;
      start = (!pBusy && !mOvr && ((mTxEn && !pTxEmpty) || (!mTxEn && mRxEn))) ? 1 : 0;
      endNow = 0;
      if (start) begin
        mBusy = 1; mSclk = 0; mCnt = mDiv; mBit = 0;
        mTxSh = mTxEn ? mTxBuf : 255;
        mTxd = mTxSh % 2;
        if (mTxEn) mTxEmpty = 1;
      end else if (pBusy) begin
        if (pCnt != 0) mCnt = pCnt - 1;
        else begin
          mCnt = mDiv;
          if (!pSclk) begin
            mSclk = 1;
            mRxSh = (mRxSh / 2) + (rxdIn ? 128 : 0);
          end else if (pBit == 7) begin
            mBusy = 0; endNow = 1;
          end else begin
            mSclk = 0; mBit = pBit + 1;
            mTxSh = (mTxSh / 2) + 128;
            mTxd = mTxSh % 2;
          end
        end
      end
      if (endNow && pTxEmpty) mTxEnd = 1;
      if (wrEn && addr == 3'd0) begin
        mTxBuf = wrData; mTxEmpty = 0; mTxEnd = 0;
      end
      if (rdEn && addr == 3'd1) mRxFull = 0;
      if (endNow && mRxEn && !pRxFull) begin
        mRxBuf = mRxSh; mRxFull = 1;
      end
      if (wrEn && addr == 3'd2 && !wrData[3]) mOvr = 0;
      if (endNow && mRxEn && pRxFull) mOvr = 1;
      if (wrEn && addr == 3'd3) begin
        mTxEn = wrData[0]; mRxEn = wrData[1];
      end
      if (wrEn && addr == 3'd4) mDiv = wrData;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    int expRd;
    if (started && !finished) begin
      case (addr)
        3'd1: expRd = mRxBuf;
        3'd2: expRd = mTxEmpty + 2*mTxEnd + 4*mRxFull + 8*mOvr;
        3'd3: expRd = mTxEn + 2*mRxEn;
        3'd4: expRd = mDiv;
        default: expRd = 0;
      endcase
      check("R3 sclk", int'(sclkOut), mSclk);
      check("R3 txd", int'(txdOut), mTxd);
      check(addr == 3'd1 ? "R4 rx byte" : "R8 register read", int'(rdData), expRd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cpuWrite(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; addr = 3'd2;
  endtask

  task automatic cpuReadRx(output logic [7:0] v);
    @(posedge clk); #1;
    rdEn = 1'b1; addr = 3'd1;
    @(negedge clk);
    v = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0; addr = 3'd2;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic statusNow(output logic [7:0] s);
    @(negedge clk);
    s = rdData;
  endtask

  initial begin
    logic [7:0] v;
    int falls;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    statusNow(v);
    check("R1 status", v, 8'h03);
    check("R1 sclk", sclkOut, 1);
    check("R1 txd", txdOut, 1);

    // full duplex, loopback, divider 1
    cpuWrite(3'd4, 8'd1);
    cpuWrite(3'd3, 8'h03);
    cpuWrite(3'd0, 8'hA5);
    statusNow(v);
    check("R2 flags after tx write", v[1:0], 0);
    cpuWrite(3'd0, 8'h3C);          // R10 written during the first frame
    statusNow(v);
    check("R2 tx byte pending", v[0], 0);
    waitCycles(100);
    statusNow(v);
    check("R6 overrun and full", v, 8'h0F);
    cpuReadRx(v);
    check("R6 first byte kept", v, 8'hA5);

    // R7 overrun blocks transfers
    cpuWrite(3'd0, 8'h0F);
    falls = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sclkOut) falls++;
    end
    check("R7 no clock while overrun", falls, 0);
    cpuWrite(3'd2, 8'h08);
    statusNow(v);
    check("R7 writing one keeps overrun", v[3], 1);
    cpuWrite(3'd2, 8'h00);
    statusNow(v);
    check("R7 writing zero clears", v[3], 0);
    waitCycles(60);
    cpuReadRx(v);
    check("R4 received byte", v, 8'h0F);
    statusNow(v);
    check("R8 idle flags", v, 8'h03);
    check("R8 clock parked", sclkOut, 1);
    check("R5 rx flag cleared", v[2], 0);

    // inverted input, divider 0
    rxInv = 1'b1;
    cpuWrite(3'd4, 8'd0);
    cpuWrite(3'd0, 8'h96);
    waitCycles(40);
    cpuReadRx(v);
    check("R4 inverted byte", v, 8'h69);

    // divider 3
    rxInv = 1'b0;
    cpuWrite(3'd4, 8'd3);
    cpuWrite(3'd0, 8'hC1);
    waitCycles(80);
    cpuReadRx(v);
    check("R3 slow divider byte", v, 8'hC1);

    // R9 transmit only
    cpuWrite(3'd4, 8'd1);
    cpuWrite(3'd3, 8'h01);
    cpuWrite(3'd0, 8'h5A);
    waitCycles(50);
    statusNow(v);
    check("R9 rx disabled leaves flag", v, 8'h03);

    // R9 both disabled: nothing moves
    cpuWrite(3'd3, 8'h00);
    cpuWrite(3'd0, 8'h11);
    falls = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sclkOut) falls++;
    end
    check("R9 disabled no clock", falls, 0);
    statusNow(v);
    check("R9 byte still pending", v[0], 0);
    cpuWrite(3'd3, 8'h03);
    waitCycles(50);
    cpuReadRx(v);
    check("R9 pending byte sent after enable", v, 8'h11);

    // R9 receive only: free-running until overrun halts it
    cpuWrite(3'd3, 8'h02);
    waitCycles(120);
    statusNow(v);
    check("R9 rx-only overrun", v, 8'h0F);
    cpuReadRx(v);
    check("R9 rx-only shifts ones", v, 8'hFF);
    cpuWrite(3'd3, 8'h00);
    cpuWrite(3'd2, 8'h00);
    waitCycles(5);
    statusNow(v);
    check("R7 cleared after stop", v, 8'h03);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule